// File: doc/BRIEF.md
# Crate Bus Command Decoder for a Serial Link Transmitter

This block sits between a crate dataway and the transmit path of a serial link. Each dataway cycle delivers a function code, a subaddress and a 16-bit write word. The block turns that cycle into an action. It can push a tagged word into a transmit FIFO, load or read an 8-bit destination address, or return a channel or transmitter status word. It can also set or clear the request-to-send and front-panel-enable flags, or reinitialise the whole module. Every cycle gets a registered X/Q response, and a read also returns data.

A FIFO write takes its two tag bits from the subaddress, and they are stored beside the data. One tag bit selects the stored destination address instead of broadcast. The other asks for an interrupt at the far end. The serial framer takes words from the FIFO head through a pop strobe. While the framer holds the internal bus for a frame, commands that need that bus are refused with Q=0.

Top module: `dataway_cmd_decoder`

## Requirements
- R1: After rst_n low, after a function 9 or function 11 command (any subaddress), or after a z_init pulse, the state is: rts=0, fp_enable=1, dest_addr=0 and the FIFO empty (head_valid=0).
- R2: Function 16 with subaddress 0 to 3 pushes {sa[1:0], wdata}. Function 0 with subaddress 0 to 3 pops the oldest entry and returns it in resp_rdata[17:0]. Bit 17 is the stored-address select (sa bit 1), bit 16 is the interrupt flag (sa bit 0), and bits 15:0 are the data. Entries come out in first-in first-out order.
- R3: A FIFO write to a full FIFO (DEPTH entries) returns X=1, Q=0 and stores nothing. A FIFO read from an empty FIFO returns X=1, Q=0 and resp_rdata=0.
- R4: Function 16 subaddress 4 loads dest_addr from wdata[7:0]. Function 0 subaddress 4 returns it in resp_rdata[7:0], with the upper bits zero.
- R5: While bus_locked=1, function 0 with subaddress 0 to 4 and function 16 with subaddress 4 return X=1, Q=0 and resp_rdata=0. They pop nothing and leave dest_addr unchanged.
- R6: Function 1 subaddress 0 returns the channel status in resp_rdata[7:0]. Bit 7 is FIFO not empty, bit 6 is FIFO not full, bit 5 is cts, bit 4 is fp_enable, and bits 3:0 are strap. All other bits are zero.
- R7: Function 1 subaddress 1 returns the transmitter status. Bit 2 is tx_underrun, bit 1 is tx_active and bit 0 is tx_enable. All other bits are zero.
- R8: Function 26 subaddress 0 sets rts and function 24 subaddress 0 clears it. Function 26 subaddress 1 sets fp_enable and function 24 subaddress 1 clears it. Each of these returns X=1, Q=1.
- R9: Function 16 with subaddress 5 to 8 is reserved. It returns X=0, Q=0 and changes no state.
- R10: Any other combination of function and subaddress returns X=0, Q=0 and changes no state.
- R11: resp_valid, resp_x, resp_q and resp_rdata are registered and appear in the cycle after cmd_strobe. resp_rdata is zero for non-read commands, and Q=1 never occurs with X=0.
- R12: head_word and head_valid show the oldest FIFO entry. A tx_pop pulse removes that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| z_init | input | 1 | Crate initialise pulse |
| cmd_strobe | input | 1 | One-cycle command valid |
| cmd_fn | input | 5 | Function code |
| cmd_sa | input | 4 | Subaddress |
| cmd_wdata | input | 16 | Write word |
| bus_locked | input | 1 | Internal bus held by a frame transmission |
| cts | input | 1 | Modem clear to send |
| strap | input | 4 | Strap setting for link rate |
| tx_underrun | input | 1 | Transmitter underrun flag |
| tx_active | input | 1 | Transmitter active flag |
| tx_enable | input | 1 | Transmitter enable flag |
| tx_pop | input | 1 | Framer removes the FIFO head |
| resp_valid | output | 1 | Response valid, one cycle after strobe |
| resp_x | output | 1 | Command recognised |
| resp_q | output | 1 | Command executed |
| resp_rdata | output | 18 | Read data |
| rts | output | 1 | Request to send |
| fp_enable | output | 1 | Front panel input enabled |
| dest_addr | output | 8 | Destination address register |
| head_word | output | 18 | Oldest FIFO entry, tags and data |
| head_valid | output | 1 | FIFO holds at least one entry |

## Verification
The hardest state to reach from the ports is a full FIFO. Only then does a write get refused, and only then does the input-ready status bit drop. The bench pushes exactly DEPTH tagged words, checks Q on each, and expects the next write to be refused. It then removes one entry with tx_pop and confirms that the host read returns the following word. The bus lock is driven per command in the vector table. This puts refused reads and address writes between normal ones, so a lost pop or a lost address update shows up on later reads.

// File: rtl/dwc_pkg.sv
`timescale 1ns/1ps
package dwc_pkg;
    localparam int FN_W = 5;
    localparam int SA_W = 4;

    localparam logic [FN_W-1:0] FN_READ   = 5'd0;
    localparam logic [FN_W-1:0] FN_STATUS = 5'd1;
    localparam logic [FN_W-1:0] FN_INIT_A = 5'd9;
    localparam logic [FN_W-1:0] FN_INIT_B = 5'd11;
    localparam logic [FN_W-1:0] FN_WRITE  = 5'd16;
    localparam logic [FN_W-1:0] FN_CLEAR  = 5'd24;
    localparam logic [FN_W-1:0] FN_SET    = 5'd26;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_FIFO_WR,
        OP_FIFO_RD,
        OP_ADDR_WR,
        OP_ADDR_RD,
        OP_CHAN_ST,
        OP_TX_ST,
        OP_RTS_SET,
        OP_RTS_CLR,
        OP_FP_SET,
        OP_FP_CLR,
        OP_INIT
    } op_e;
endpackage

// File: rtl/dwc_decode.sv
`timescale 1ns/1ps
module dwc_decode
    import dwc_pkg::*;
(
    input  logic [FN_W-1:0] fn,
    input  logic [SA_W-1:0] sa,
    output op_e             op
);
    logic sa_fifo;
    logic sa_addr;

    always_comb begin
        sa_fifo = (sa <= 4'd3);
        sa_addr = (sa == 4'd4);
        op      = OP_NONE;
        unique case (fn)
            FN_WRITE: begin
                if (sa_fifo)      op = OP_FIFO_WR;
                else if (sa_addr) op = OP_ADDR_WR;
            end
            FN_READ: begin
                if (sa_fifo)      op = OP_FIFO_RD;
                else if (sa_addr) op = OP_ADDR_RD;
            end
            FN_STATUS: begin
                if (sa == 4'd0)      op = OP_CHAN_ST;
                else if (sa == 4'd1) op = OP_TX_ST;
            end
            FN_SET: begin
                if (sa == 4'd0)      op = OP_RTS_SET;
                else if (sa == 4'd1) op = OP_FP_SET;
            end
            FN_CLEAR: begin
                if (sa == 4'd0)      op = OP_RTS_CLR;
                else if (sa == 4'd1) op = OP_FP_CLR;
            end
            FN_INIT_A, FN_INIT_B: op = OP_INIT;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/dwc_fifo.sv
`timescale 1ns/1ps
module dwc_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty = (p_q.cnt == '0);
    assign full  = (p_q.cnt == CNT_W'(DEPTH));
    assign head  = mem[p_q.rd];

    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
        p_d     = p_q;
        if (do_push) p_d.wr = (p_q.wr == LAST) ? '0 : p_q.wr + 1'b1;
        if (do_pop)  p_d.rd = (p_q.rd == LAST) ? '0 : p_q.rd + 1'b1;
        p_d.cnt = p_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        if (flush) p_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[p_q.wr] <= push_data;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/dataway_cmd_decoder.sv
`timescale 1ns/1ps
module dataway_cmd_decoder
    import dwc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int TAG_W   = 2,
    parameter int ADDR_W  = 8,
    parameter int DEPTH   = 64,
    parameter int STRAP_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    z_init,
    input  logic                    cmd_strobe,
    input  logic [FN_W-1:0]         cmd_fn,
    input  logic [SA_W-1:0]         cmd_sa,
    input  logic [DATA_W-1:0]       cmd_wdata,
    input  logic                    bus_locked,
    input  logic                    cts,
    input  logic [STRAP_W-1:0]      strap,
    input  logic                    tx_underrun,
    input  logic                    tx_active,
    input  logic                    tx_enable,
    input  logic                    tx_pop,
    output logic                    resp_valid,
    output logic                    resp_x,
    output logic                    resp_q,
    output logic [TAG_W+DATA_W-1:0] resp_rdata,
    output logic                    rts,
    output logic                    fp_enable,
    output logic [ADDR_W-1:0]       dest_addr,
    output logic [TAG_W+DATA_W-1:0] head_word,
    output logic                    head_valid
);
    localparam int WORD_W = TAG_W + DATA_W;

    typedef struct packed {
        logic              rts;
        logic              fp_en;
        logic [ADDR_W-1:0] addr;
        logic              rvalid;
        logic              x;
        logic              q;
        logic [WORD_W-1:0] rdata;
    } state_t;

    state_t s_d, s_q;
    op_e    op;
    logic   ok;
    logic   f_push, f_pop, f_flush, f_empty, f_full;
    logic [WORD_W-1:0] f_head;

    dwc_decode u_decode (
        .fn (cmd_fn),
        .sa (cmd_sa),
        .op (op)
    );

    dwc_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (f_flush),
        .push      (f_push),
        .push_data ({cmd_sa[TAG_W-1:0], cmd_wdata}),
        .pop       (f_pop),
        .head      (f_head),
        .empty     (f_empty),
        .full      (f_full)
    );

    always_comb begin
        unique case (op)
            OP_NONE:    ok = 1'b0;
            OP_FIFO_WR: ok = !f_full;
            OP_FIFO_RD: ok = !f_empty && !bus_locked;
            OP_ADDR_WR,
            OP_ADDR_RD: ok = !bus_locked;
            default:    ok = 1'b1;
        endcase

        f_push  = cmd_strobe && (op == OP_FIFO_WR) && ok;
        f_pop   = (cmd_strobe && (op == OP_FIFO_RD) && ok) || tx_pop;
        f_flush = z_init || (cmd_strobe && (op == OP_INIT));

        s_d        = s_q;
        s_d.rvalid = cmd_strobe;
        s_d.x      = cmd_strobe && (op != OP_NONE);
        s_d.q      = cmd_strobe && ok;
        s_d.rdata  = '0;

        if (cmd_strobe && ok) begin
            unique case (op)
                OP_FIFO_RD: s_d.rdata = f_head;
                OP_ADDR_WR: s_d.addr  = cmd_wdata[ADDR_W-1:0];
                OP_ADDR_RD: s_d.rdata = WORD_W'(s_q.addr);
                OP_CHAN_ST: s_d.rdata = WORD_W'({!f_empty, !f_full, cts,
                                                 s_q.fp_en, strap});
                OP_TX_ST:   s_d.rdata = WORD_W'({tx_underrun, tx_active,
                                                 tx_enable});
                OP_RTS_SET: s_d.rts   = 1'b1;
                OP_RTS_CLR: s_d.rts   = 1'b0;
                OP_FP_SET:  s_d.fp_en = 1'b1;
                OP_FP_CLR:  s_d.fp_en = 1'b0;
                default: ;
            endcase
        end

        if (f_flush) begin
            s_d.rts   = 1'b0;
            s_d.fp_en = 1'b1;
            s_d.addr  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.fp_en <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign resp_valid = s_q.rvalid;
    assign resp_x     = s_q.x;
    assign resp_q     = s_q.q;
    assign resp_rdata = s_q.rdata;
    assign rts        = s_q.rts;
    assign fp_enable  = s_q.fp_en;
    assign dest_addr  = s_q.addr;
    assign head_word  = f_head;
    assign head_valid = !f_empty;

    // R11
    q_needs_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_q |-> (resp_x && resp_valid));

    // R1
    init_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && (cmd_fn == FN_INIT_A || cmd_fn == FN_INIT_B))
        |=> (!rts && fp_enable && dest_addr == '0 && !head_valid));

    // R5
    locked_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && bus_locked && !z_init && cmd_fn == FN_WRITE && cmd_sa == 4'd4)
        |=> (!resp_q && $stable(dest_addr)));

    // R8
    rts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && !z_init && cmd_fn == FN_SET && cmd_sa == 4'd0) |=> rts);

    // R9
    reserved_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_fn == FN_WRITE && cmd_sa >= 4'd5 && cmd_sa <= 4'd8)
        |=> (resp_valid && !resp_x && !resp_q && resp_rdata == '0));
endmodule

// File: tb/dataway_cmd_decoder_bench.sv
`timescale 1ns/1ps
module dataway_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        z_init = 1'b0;
    logic        cmd_strobe = 1'b0;
    logic [4:0]  cmd_fn = '0;
    logic [3:0]  cmd_sa = '0;
    logic [15:0] cmd_wdata = '0;
    logic        bus_locked = 1'b0;
    logic        cts = 1'b1;
    logic [3:0]  strap = 4'hA;
    logic        tx_underrun = 1'b0;
    logic        tx_active = 1'b1;
    logic        tx_enable = 1'b1;
    logic        tx_pop = 1'b0;
    logic        resp_valid, resp_x, resp_q, rts, fp_enable, head_valid;
    logic [17:0] resp_rdata, head_word;
    logic [7:0]  dest_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dataway_cmd_decoder u_dataway_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .z_init(z_init), .cmd_strobe(cmd_strobe),
        .cmd_fn(cmd_fn), .cmd_sa(cmd_sa), .cmd_wdata(cmd_wdata),
        .bus_locked(bus_locked), .cts(cts), .strap(strap),
        .tx_underrun(tx_underrun), .tx_active(tx_active), .tx_enable(tx_enable),
        .tx_pop(tx_pop), .resp_valid(resp_valid), .resp_x(resp_x),
        .resp_q(resp_q), .resp_rdata(resp_rdata), .rts(rts),
        .fp_enable(fp_enable), .dest_addr(dest_addr), .head_word(head_word),
        .head_valid(head_valid)
    );

    typedef struct packed {
        logic [4:0]  fn;
        logic [3:0]  sa;
        logic [15:0] wd;
        logic        lock;
        logic        x;
        logic        q;
        logic [17:0] rd;
        logic        rts;
        logic        fp;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{5'd1,  4'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h0007A, 1'b0, 1'b1}, // R6
        '{5'd16, 4'd4, 16'h005C, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b0, 1'b1}, // R4
        '{5'd0,  4'd4, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h0005C, 1'b0, 1'b1}, // R4
        '{5'd16, 4'd4, 16'h0033, 1'b1, 1'b1, 1'b0, 18'h00000, 1'b0, 1'b1}, // R5
        '{5'd0,  4'd4, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h0005C, 1'b0, 1'b1}, // R5
        '{5'd0,  4'd4, 16'h0000, 1'b1, 1'b1, 1'b0, 18'h00000, 1'b0, 1'b1}, // R5
        '{5'd16, 4'd1, 16'h1234, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b0, 1'b1}, // R2
        '{5'd16, 4'd2, 16'hBEEF, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b0, 1'b1}, // R2
        '{5'd1,  4'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h000FA, 1'b0, 1'b1}, // R6
        '{5'd0,  4'd0, 16'h0000, 1'b1, 1'b1, 1'b0, 18'h00000, 1'b0, 1'b1}, // R5
        '{5'd0,  4'd3, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h11234, 1'b0, 1'b1}, // R2
        '{5'd0,  4'd1, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h2BEEF, 1'b0, 1'b1}, // R2
        '{5'd0,  4'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 18'h00000, 1'b0, 1'b1}, // R3
        '{5'd16, 4'd6, 16'h0F0F, 1'b0, 1'b0, 1'b0, 18'h00000, 1'b0, 1'b1}, // R9
        '{5'd16, 4'd8, 16'h0F0F, 1'b0, 1'b0, 1'b0, 18'h00000, 1'b0, 1'b1}, // R9
        '{5'd1,  4'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h0007A, 1'b0, 1'b1}, // R9
        '{5'd17, 4'd8, 16'h00AA, 1'b0, 1'b0, 1'b0, 18'h00000, 1'b0, 1'b1}, // R10
        '{5'd26, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b1, 1'b1}, // R8
        '{5'd24, 4'd1, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b1, 1'b0}, // R8
        '{5'd1,  4'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h0006A, 1'b1, 1'b0}, // R6
        '{5'd1,  4'd1, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h00003, 1'b1, 1'b0}, // R7
        '{5'd26, 4'd1, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b1, 1'b1}, // R8
        '{5'd24, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b0, 1'b1}, // R8
        '{5'd26, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b1, 1'b1}, // R8
        '{5'd16, 4'd3, 16'hCAFE, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b1, 1'b1}, // R2
        '{5'd11, 4'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b0, 1'b1}, // R1
        '{5'd0,  4'd4, 16'h0000, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b0, 1'b1}, // R1
        '{5'd0,  4'd2, 16'h0000, 1'b0, 1'b1, 1'b0, 18'h00000, 1'b0, 1'b1}  // R1
    };

    task automatic check(input bit good, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on a falling edge; the response is registered at the next rising
    // edge and sampled at the following falling edge.
    task automatic run_cmd(input logic [4:0] fn, input logic [3:0] sa,
                           input logic [15:0] wd, input logic lock);
        @(negedge clk);
        cmd_strobe = 1'b1; cmd_fn = fn; cmd_sa = sa; cmd_wdata = wd;
        bus_locked = lock;
        @(negedge clk);
        cmd_strobe = 1'b0; bus_locked = 1'b0;
    endtask

    task automatic expect_resp(input string req, input logic x, input logic q,
                               input logic [17:0] rd);
        check(resp_valid === 1'b1 && resp_x === x && resp_q === q && resp_rdata === rd,
              req, {resp_valid, resp_x, resp_q, 11'd0, resp_rdata},
              {1'b1, x, q, 11'd0, rd});
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R11 no response without strobe
        check(!rts && fp_enable && dest_addr == 8'h00 && !head_valid && !resp_valid,
              "R1 reset", {rts, fp_enable, dest_addr, head_valid, resp_valid},
              {1'b0, 1'b1, 8'h00, 1'b0, 1'b0});

        for (int i = 0; i < NV; i++) begin
            run_cmd(VECS[i].fn, VECS[i].sa, VECS[i].wd, VECS[i].lock);
            // R11 registered response, R2 tag layout
            check(resp_valid === 1'b1 && resp_x === VECS[i].x && resp_q === VECS[i].q &&
                  resp_rdata === VECS[i].rd && rts === VECS[i].rts &&
                  fp_enable === VECS[i].fp,
                  $sformatf("R11 vector %0d", i),
                  {resp_x, resp_q, resp_rdata, rts, fp_enable},
                  {VECS[i].x, VECS[i].q, VECS[i].rd, VECS[i].rts, VECS[i].fp});
        end

        // R3 fill to capacity, then one refused write
        for (int i = 0; i < 64; i++) begin
            run_cmd(5'd16, 4'd0, 16'h0100 + 16'(i), 1'b0);
            expect_resp("R3 fill", 1'b1, 1'b1, 18'h0);
        end
        run_cmd(5'd16, 4'd0, 16'hDEAD, 1'b0);
        expect_resp("R3 full refused", 1'b1, 1'b0, 18'h0);
        run_cmd(5'd1, 4'd0, 16'h0, 1'b0);
        expect_resp("R6 full status", 1'b1, 1'b1, 18'h000BA);

        // R12 framer pop
        check(head_valid && head_word == 18'h00100, "R12 head",
              {head_valid, head_word}, {1'b1, 18'h00100});
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
        check(head_valid && head_word == 18'h00101, "R12 pop",
              {head_valid, head_word}, {1'b1, 18'h00101});
        run_cmd(5'd0, 4'd0, 16'h0, 1'b0);
        expect_resp("R2 read after pop", 1'b1, 1'b1, 18'h00101);
        run_cmd(5'd16, 4'd0, 16'h7777, 1'b0);
        expect_resp("R3 room again", 1'b1, 1'b1, 18'h0);

        // R1 crate initialise pulse
        run_cmd(5'd16, 4'd4, 16'h0077, 1'b0);
        run_cmd(5'd26, 4'd0, 16'h0, 1'b0);
        run_cmd(5'd24, 4'd1, 16'h0, 1'b0);
        check(rts && !fp_enable && dest_addr == 8'h77, "R8 before init",
              {rts, fp_enable, dest_addr}, {1'b1, 1'b0, 8'h77});
        @(negedge clk); z_init = 1'b1;
        @(negedge clk); z_init = 1'b0;
        check(!rts && fp_enable && dest_addr == 8'h00 && !head_valid, "R1 z_init",
              {rts, fp_enable, dest_addr, head_valid}, {1'b0, 1'b1, 8'h00, 1'b0});

        // R1 function 9
        run_cmd(5'd16, 4'd2, 16'h4242, 1'b0);
        run_cmd(5'd9, 4'd7, 16'h0, 1'b0);
        expect_resp("R1 fn9", 1'b1, 1'b1, 18'h0);
        check(!head_valid, "R1 fn9 flush", {31'd0, head_valid}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule